// File: doc/BRIEF.md
# Line-Buffered Binary 3x3 Convolution Engine

The engine takes one binarized feature map per frame as a raster-ordered stream of 16-bit pixel words. Each word packs sixteen one-bit channels. A three-row line buffer turns the stream into 3x3 windows. For every output position, the engine scores each window against a bank of 32 filters held in an internal weight store. Each of the nine taps adds 16 minus twice the number of differing bits between the pixel word and the weight word. The sum of the nine taps is a signed 32-bit result, so each output is a binary dot product over 144 bit pairs.

Software loads the weights through a write port while no frame is running. Pixels then arrive over a valid/ready handshake. Once the third and later input rows are complete, the engine stops taking pixels and emits the six outputs of that row for all 32 filters. Each result carries its filter index. When the row's results are out, the engine resumes accepting input. Frames repeat back to back with no extra control.

Top module: `bconv_line_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A write with `wr_en` high stores `wr_word` as filter `wr_filt`, tap `wr_tap`, where tap = 3·kernel_row + kernel_col. The write takes effect only while the engine is idle: no pixel of the current frame has yet been accepted, and no result of the previous frame is still pending. A write issued mid-frame changes no result.
- R3: The result for output row y, column x and filter f uses the input pixels at rows y..y+2 and columns x..x+2. Kernel row k maps to input row y+k, and kernel column j maps to input column x+j.
- R4: Each tap contributes 16 − 2·popcount(pixel XOR weight). The result is the sum of the nine taps, so it always lies within −144..144.
- R5: No result appears before input row 2 is complete. The results for output row y become valid only after exactly (y+3)·8 pixels of the frame have been accepted. `in_ready` stays 0 while results are pending, and the output phase starts on the cycle after a pixel is accepted.
- R6: Results come out ordered by output row, then output column, then filter index 0..31. `out_filt` gives that index, and each frame produces 6·6·32 results.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sum` and `out_filt` hold their values.
- R8: After the last result of a frame, the engine is idle. It then accepts a new frame starting at row 0, using the weights in its store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Weight write strobe |
| wr_filt | input | 5 | Filter index of the write |
| wr_tap | input | 4 | Tap index of the write (3·row + col) |
| wr_word | input | 16 | Weight word |
| in_valid | input | 1 | Pixel word valid |
| in_ready | output | 1 | Engine accepts a pixel |
| in_pix | input | 16 | Pixel word, 16 binary channels |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_sum | output | 32 | Signed accumulated result |
| out_filt | output | 5 | Filter index of the result |

## Verification
The assertions check several properties on every cycle. A stalled result must hold steady. Filter indices must step by one and wrap from 31 to 0. Every result must stay within ±144. Output must begin only right after an accepted pixel.

Some behaviour can only be shown by the bench scenarios against an independent model. These include the correct window alignment across rows and columns, and the exact tap arithmetic under uniform, inverted and random data. They also cover the pixel count at which each output row starts, that a mid-frame weight write is dropped, and that back-to-back frames reuse the stored weights. The scenarios apply random gaps on both handshakes.

// File: rtl/bconv_line_engine.sv
module bconv_line_engine #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int CH    = 16,
  parameter int NF    = 32,
  parameter int K     = 3,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NF)-1:0]   wr_filt,
  input  logic [$clog2(K*K)-1:0]  wr_tap,
  input  logic [CH-1:0]           wr_word,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CH-1:0]           in_pix,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_sum,
  output logic [$clog2(NF)-1:0]   out_filt
);
  localparam int OW   = COLS - K + 1;
  localparam int TAPS = K * K;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int FW   = $clog2(NF);
  localparam int TW   = $clog2(TAPS);
  localparam int MAXV = CH * TAPS;

  logic [CH-1:0] lbuf [K][COLS];
  logic [CH-1:0] wmem [NF][TAPS];
  logic [RW-1:0] row;
  logic [CW-1:0] col, ox;
  logic [FW-1:0] fi;
  logic          busy;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_filt  = fi;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;
  wire idle     = !busy && row == '0 && col == '0;

  always_ff @(posedge clk) begin
    if (in_fire) begin
      for (int k = 0; k < K - 1; k++) lbuf[k][col] <= lbuf[k+1][col];
      lbuf[K-1][col] <= in_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && idle && int'(wr_tap) < TAPS) wmem[wr_filt][wr_tap] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row  <= '0;
      col  <= '0;
      ox   <= '0;
      fi   <= '0;
      busy <= 1'b0;
    end else if (in_fire) begin
      if (col == CW'(COLS - 1)) begin
        col <= '0;
        if (int'(row) >= K - 1) busy <= 1'b1;
        else row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end else if (out_fire) begin
      if (fi == FW'(NF - 1)) begin
        fi <= '0;
        if (ox == CW'(OW - 1)) begin
          ox   <= '0;
          busy <= 1'b0;
          row  <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
        end else begin
          ox <= ox + 1'b1;
        end
      end else begin
        fi <= fi + 1'b1;
      end
    end
  end

  always_comb begin
    out_sum = '0;
    for (int ky = 0; ky < K; ky++) begin
      for (int kx = 0; kx < K; kx++) begin
        if (int'(ox) + kx < COLS)
          out_sum = out_sum + ACC_W'(CH - 2 * $countones(
                      lbuf[ky][CW'(int'(ox) + kx)] ^ wmem[fi][TW'(ky * K + kx)]));
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_filt));

  p_filt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_filt != FW'(NF - 1) |=> out_valid && out_filt == $past(out_filt) + 1'b1);

  p_filt_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_filt == FW'(NF - 1) |=> out_filt == '0);

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sum) >= -MAXV) && (int'(out_sum) <= MAXV));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/bconv_line_engine_tb.sv
module bconv_line_engine_tb;
  localparam int NOUT = 6 * 6 * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_filt = '0;
  logic [3:0] wr_tap = '0;
  logic [15:0] wr_word = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [31:0] out_sum;
  logic [4:0] out_filt;

  int total = 0;
  int bad = 0;
  int px_cnt = 0;
  bit done = 1'b0;
  logic [15:0] img [8][8];
  logic [15:0] wt [32][9];

  always #5 clk = ~clk;

  bconv_line_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_filt(wr_filt), .wr_tap(wr_tap),
    .wr_word(wr_word), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_filt(out_filt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(int y, int x, int f);
    int s = 0;
    for (int ky = 0; ky < 3; ky++)
      for (int kx = 0; kx < 3; kx++)
        s += 16 - 2 * $countones(img[y+ky][x+kx] ^ wt[f][ky*3+kx]);
    return s;
  endfunction

  task automatic t_reset_r1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_load_r2(input int mode);
    for (int f = 0; f < 32; f++)
      for (int t = 0; t < 9; t++) begin
        wt[f][t] = (mode == 0) ? 16'h0000 : 16'($urandom);
        @(negedge clk);
        wr_en = 1'b1; wr_filt = 5'(f); wr_tap = 4'(t); wr_word = wt[f][t];
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_frame(input string name, input bit mid_write, input bit full_ready);
    px_cnt = 0;
    fork
      begin
        for (int p = 0; p < 64; p++) begin
          while (!full_ready && $urandom_range(0, 3) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
          end
          in_valid = 1'b1;
          in_pix = img[p/8][p%8];
          while (!in_ready) @(negedge clk);
          px_cnt++;
          @(negedge clk);
          in_valid = 1'b0;
          if (mid_write && p == 9) begin
            wr_en = 1'b1; wr_filt = 5'd0; wr_tap = 4'd4; wr_word = ~wt[0][4];
            @(negedge clk);
            wr_en = 1'b0;
          end
        end
      end
      begin
        int n = 0;
        bit held = 1'b0;
        int hs = 0;
        int hf = 0;
        while (n < NOUT) begin
          @(negedge clk);
          if (held && out_valid) begin
            chk(int'(out_sum) == hs && int'(out_filt) == hf, "R7 hold", int'(out_sum), hs);
          end
          held = 1'b0;
          out_ready = full_ready ? 1'b1 : ($urandom_range(0, 3) != 0);
          if (out_valid) begin
            if (out_ready) begin
              int y = n / 192;
              int x = (n / 32) % 6;
              int f = n % 32;
              chk(int'(out_filt) == f, "R6 filter order", int'(out_filt), f);
              chk(int'(out_sum) == expv(y, x, f), "R3 R4 result", int'(out_sum), expv(y, x, f));
              if (x == 0 && f == 0) begin
                chk(px_cnt == (y + 3) * 8, "R5 row start", px_cnt, (y + 3) * 8);
                chk(in_ready == 1'b0, "R5 input stalled", int'(in_ready), 0);
              end
              n++;
            end else begin
              held = 1'b1;
              hs = int'(out_sum);
              hf = int'(out_filt);
            end
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    chk(out_valid == 1'b0, "R8 idle after frame", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 ready after frame", int'(in_ready), 1);
    $display("frame %s complete", name);
  endtask

  initial begin
    t_reset_r1();
    t_load_r2(0);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) img[r][c] = 16'h0000;
    t_frame("zero", 1'b0, 1'b0);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) img[r][c] = 16'hFFFF;
    t_frame("inverted", 1'b0, 1'b0);
    t_load_r2(1);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) img[r][c] = 16'($urandom);
    t_frame("random_midwrite_R2", 1'b1, 1'b0);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) img[r][c] = 16'(r * 8 + c) ^ 16'hA5C3;
    t_frame("repeat_R8", 1'b0, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule